// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits in the fetch stage of a pipelined processor. Each cycle it looks up the fetch address in two structures. A direction table is indexed by low address bits and has no tags. A small tagged cache holds branch targets. From these it gives a taken/not-taken guess and the next fetch address. Fetch carries the guess and the guessed target into decode along with the instruction.

When decode resolves a branch, it presents the real outcome and target on the update port, together with the prediction that travelled with the instruction. In that same cycle the block raises a mispredict flag and a redirect address, so that fetch can drop the wrongly fetched instruction and restart on the correct path. At the next clock edge the tables take the new outcome.

The parameter `CTR_W` selects the direction entry format. With 1, each entry is one bit that follows the last outcome. With 2, each entry is a saturating counter with hysteresis. The total direction storage is fixed by `DIR_BITS`, and the number of entries is `DIR_BITS / CTR_W`.

Top module: `branch_predictor`

## Requirements
- R1: After reset every direction entry is zero (not taken) and every target cache entry is invalid, so `pred_taken` is 0 and `pred_target` equals `fetch_pc + 4` for any address.
- R2: `pred_taken` is 1 only when the direction entry's most significant bit is 1 and the target cache hits; `pred_target` is then the cached target, and otherwise `fetch_pc + 4`.
- R3: With `CTR_W = 1`, an update writes the actual outcome into the entry, so a wrong bit is inverted and a right bit is kept.
- R4: With `CTR_W = 2`, entry values 3 and 2 predict taken and 1 and 0 predict not taken. A taken update increments the entry and a not-taken update decrements it, both saturating, so a strong state needs two wrong outcomes in a row before the prediction changes.
- R5: The direction entry is selected by `fetch_pc[IDX+1:2]` with no tag, so two addresses that differ only above those bits share one entry.
- R6: The target cache is direct mapped on `pc[BTB_IW+1:2]`, with a valid bit and the remaining upper address bits as its tag. A taken update fills the entry. A lookup that misses predicts not taken, whatever the direction entry holds.
- R7: With `upd_valid` high, `mispredict` is 1 when `upd_taken` differs from `upd_pred_taken`, or when both are 1 and `upd_pred_target` differs from `upd_target`. `redirect_pc` is `upd_target` for a taken branch and `upd_pc + 4` otherwise.
- R8: A lookup and an update in the same cycle on the same entry return the contents from before the update; the new contents appear after the clock edge.
- R9: A loop branch that is taken nine times and then not taken once is mispredicted twice per pass with `CTR_W = 1` and, once warmed up, once per pass with `CTR_W = 2`.
- R10: While `upd_valid` is 0, `mispredict` stays 0 and neither table changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_target | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | PC_W | Actual taken target |
| upd_pred_taken | input | 1 | Direction that was predicted for this branch |
| upd_pred_target | input | PC_W | Target that was predicted for this branch |
| mispredict | output | 1 | Flush and redirect request |
| redirect_pc | output | PC_W | Correct next fetch address |

## Verification
The assertions assume that `upd_pred_taken` and `upd_pred_target` are values the block produced earlier for the same address. They also assume that addresses are word aligned and that reset is held until the inputs are quiet. The bench keeps to this. It presents each branch first on the fetch side, latches the prediction, and feeds exactly that prediction back on the update port in the following step. It changes inputs only between clock edges, and it keeps `upd_valid` low during reset.

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int PC_W        = 32,
  parameter int DIR_BITS    = 4096,
  parameter int CTR_W       = 2,
  parameter int BTB_ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_pred_taken,
  input  logic [PC_W-1:0] upd_pred_target,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int DIR_N  = DIR_BITS / CTR_W;
  localparam int DIR_IW = $clog2(DIR_N);
  localparam int BTB_IW = $clog2(BTB_ENTRIES);
  localparam int TAG_W  = PC_W - BTB_IW - 2;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [DIR_BITS-1:0]    dir_q;
  logic [BTB_ENTRIES-1:0] btb_v;
  logic [TAG_W-1:0]       btb_tag [BTB_ENTRIES];
  logic [PC_W-1:0]        btb_tgt [BTB_ENTRIES];

  // lookup side
  wire [DIR_IW-1:0] f_di  = fetch_pc[DIR_IW+1:2];
  wire [BTB_IW-1:0] f_bi  = fetch_pc[BTB_IW+1:2];
  wire [TAG_W-1:0]  f_tag = fetch_pc[PC_W-1:BTB_IW+2];
  wire [CTR_W-1:0]  f_ctr = dir_q[f_di*CTR_W +: CTR_W];
  wire              f_hit = btb_v[f_bi] && (btb_tag[f_bi] == f_tag);

  assign pred_taken  = f_ctr[CTR_W-1] && f_hit;
  assign pred_target = pred_taken ? btb_tgt[f_bi] : fetch_pc + PC_W'(4);

  // resolution side
  wire [DIR_IW-1:0] u_di  = upd_pc[DIR_IW+1:2];
  wire [BTB_IW-1:0] u_bi  = upd_pc[BTB_IW+1:2];
  wire [TAG_W-1:0]  u_tag = upd_pc[PC_W-1:BTB_IW+2];
  wire [CTR_W-1:0]  u_ctr = dir_q[u_di*CTR_W +: CTR_W];
  logic [CTR_W-1:0] u_ctr_nxt;

  generate
    if (CTR_W == 1) begin : g_last_outcome
      assign u_ctr_nxt = upd_taken;
    end else begin : g_hysteresis
      always_comb begin
        u_ctr_nxt = u_ctr;
        if (upd_taken && u_ctr != CTR_MAX)      u_ctr_nxt = u_ctr + 1'b1;
        else if (!upd_taken && u_ctr != '0)     u_ctr_nxt = u_ctr - 1'b1;
      end
    end
  endgenerate

  wire dir_wrong = upd_taken != upd_pred_taken;
  wire tgt_wrong = upd_taken && upd_pred_taken && (upd_pred_target != upd_target);

  assign mispredict  = upd_valid && (dir_wrong || tgt_wrong);
  assign redirect_pc = upd_taken ? upd_target : upd_pc + PC_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      btb_v <= '0;
    end else if (upd_valid) begin
      dir_q[u_di*CTR_W +: CTR_W] <= u_ctr_nxt;
      if (upd_taken) btb_v[u_bi] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid && upd_taken) begin
      btb_tag[u_bi] <= u_tag;
      btb_tgt[u_bi] <= upd_target;
    end
  end
endmodule

// File: rtl/branch_predictor_chk.sv
module branch_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int CTR_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_pred_taken,
  input logic [PC_W-1:0] upd_pred_target,
  input logic            mispredict,
  input logic [PC_W-1:0] redirect_pc
);
  a_r1_reset_cold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pred_taken && pred_target == fetch_pc + PC_W'(4)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !mispredict);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!$stable(fetch_pc) || ($stable(pred_taken) && $stable(pred_target))));

  a_r7_fallthru_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict && !upd_taken) |-> redirect_pc == upd_pc + PC_W'(4));

  a_r7_agree_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_pred_taken) |-> !mispredict);

  generate
    if (CTR_W == 1) begin : g_one
      a_r3_follow_nt: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_pc == fetch_pc) |=> (!$stable(fetch_pc) || !pred_taken));
    end
  endgenerate
endmodule

bind branch_predictor branch_predictor_chk #(.PC_W(PC_W), .CTR_W(CTR_W)) u_chk (.*);

// File: tb/test_branch_predictor.sv
`timescale 1ns/1ps
module test_branch_predictor;
  localparam int PC_W = 32;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic [PC_W-1:0] upd_pc = '0, upd_target = '0;
  logic up2 = 0, up1 = 0;
  logic [PC_W-1:0] ut2 = '0, ut1 = '0;

  logic pt2, pt1, mis2, mis1;
  logic [PC_W-1:0] ptg2, ptg1, rd2, rd1;

  int total = 0, bad = 0;
  bit m2, m1;

  always #10 clk = ~clk;

  branch_predictor #(.CTR_W(2)) i_branch_predictor (
    .clk, .rst_n, .fetch_pc, .pred_taken(pt2), .pred_target(ptg2),
    .upd_valid, .upd_pc, .upd_taken, .upd_target,
    .upd_pred_taken(up2), .upd_pred_target(ut2),
    .mispredict(mis2), .redirect_pc(rd2));

  branch_predictor #(.CTR_W(1)) i_branch_predictor_1b (
    .clk, .rst_n, .fetch_pc, .pred_taken(pt1), .pred_target(ptg1),
    .upd_valid, .upd_pc, .upd_taken, .upd_target,
    .upd_pred_taken(up1), .upd_pred_target(ut1),
    .mispredict(mis1), .redirect_pc(rd1));

  task automatic chk(string req, logic [PC_W-1:0] got, logic [PC_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // fetch, carry prediction, resolve; leaves time 1ns after the edge
  task automatic branch(logic [PC_W-1:0] pc, bit tk, logic [PC_W-1:0] tgt);
    fetch_pc = pc;
    #1;
    up2 = pt2; ut2 = ptg2; up1 = pt1; ut1 = ptg1;
    upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    #1;
    m2 = mis2; m1 = mis1;
    chk("R7 redirect 2b", rd2, tk ? tgt : pc + 4);
    chk("R7 redirect 1b", rd1, tk ? tgt : pc + 4);
    @(posedge clk); #1;
    upd_valid = 0;
  endtask

  task automatic t_reset;
    fetch_pc = 32'h100; #1;
    chk("R1 pred 2b", pt2, 0);
    chk("R1 pred 1b", pt1, 0);
    chk("R1 target", ptg2, 32'h104);
    chk("R1 no mispredict", mis1, 0);
  endtask

  task automatic t_onebit;
    branch(32'h200, 1, 32'h800);
    chk("R3 first taken missed", m1, 1);
    fetch_pc = 32'h200; #1;
    chk("R3 bit set", pt1, 1);
    chk("R2 cached target", ptg1, 32'h800);
    branch(32'h200, 0, 32'h800);
    chk("R3 not taken missed", m1, 1);
    fetch_pc = 32'h200; #1;
    chk("R3 bit inverted", pt1, 0);
    chk("R2 fall through", ptg1, 32'h204);
  endtask

  task automatic t_twobit;
    branch(32'h300, 1, 32'h900);
    chk("R4 0->1 missed", m2, 1);
    fetch_pc = 32'h300; #1; chk("R4 state1 not taken", pt2, 0);
    branch(32'h300, 1, 32'h900);
    chk("R4 1->2 missed", m2, 1);
    fetch_pc = 32'h300; #1; chk("R4 state2 taken", pt2, 1);
    branch(32'h300, 1, 32'h900);
    chk("R4 2->3 hit", m2, 0);
    branch(32'h300, 0, 32'h900);
    chk("R4 3->2 missed", m2, 1);
    fetch_pc = 32'h300; #1; chk("R4 one miss keeps taken", pt2, 1);
    branch(32'h300, 0, 32'h900);
    chk("R4 2->1 missed", m2, 1);
    fetch_pc = 32'h300; #1; chk("R4 two misses flip", pt2, 0);
  endtask

  task automatic t_alias;
    branch(32'h400, 1, 32'hA00);
    fetch_pc = 32'h400; #1; chk("R5 trained", pt1, 1);
    // 0x4400 shares direction entry (1b: 4096 entries) and target slot, other tag
    fetch_pc = 32'h4400; #1;
    chk("R6 tag miss predicts not taken", pt1, 0);
    chk("R6 miss target", ptg1, 32'h4404);
    branch(32'h4400, 0, 32'h0);
    chk("R6 correct not taken", m1, 0);
    fetch_pc = 32'h400; #1;
    chk("R5 alias cleared shared bit", pt1, 0);
  endtask

  task automatic t_target;
    branch(32'h500, 1, 32'hB00);
    branch(32'h500, 1, 32'hC00);
    chk("R7 target change mispredict", m1, 1);
    fetch_pc = 32'h500; #1;
    chk("R6 target refilled", ptg1, 32'hC00);
  endtask

  task automatic t_same;
    fetch_pc = 32'h600;
    upd_valid = 1; upd_pc = 32'h600; upd_taken = 1; upd_target = 32'hD00;
    up1 = 0; up2 = 0; ut1 = 0; ut2 = 0;
    #1;
    chk("R8 same cycle old value", pt1, 0);
    @(posedge clk); #1;
    upd_valid = 0; #1;
    chk("R8 new value after edge", pt1, 1);
    chk("R8 new target", ptg1, 32'hD00);
  endtask

  task automatic t_idle;
    fetch_pc = 32'h600;
    upd_pc = 32'h600; upd_taken = 0; upd_target = 32'h0; up1 = 1;
    #1;
    chk("R10 no mispredict", mis1, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R10 table unchanged", pt1, 1);
  endtask

  task automatic t_loop;
    for (int v = 0; v < 3; v++) begin
      int c2 = 0, c1 = 0;
      for (int i = 0; i < 10; i++) begin
        branch(32'h700, i < 9, 32'h680);
        c2 += m2; c1 += m1;
      end
      chk($sformatf("R9 1b pass %0d", v), c1, 2);
      chk($sformatf("R9 2b pass %0d", v), c2, v == 0 ? 3 : 1);
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_onebit;
    t_twobit;
    t_alias;
    t_target;
    t_same;
    t_idle;
    t_loop;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule